// File: doc/BRIEF.md
# Single-Bus Microsequenced Processor Datapath

This block is a very small processor core. Every storage element shares one internal data bus: four general registers, the program counter, the memory address and memory data latches, the instruction latch, an ALU operand latch and an ALU result latch. A hardwired step counter raises exactly one bus-drive strobe per clock and the load strobes of the elements that take the bus value. The counter steps through a three-step fetch and then the steps of one of four operations: register add, add of a word read from memory, a relative jump taken when the zero flag is set, and an opcode that does nothing.

The core talks to a synchronous memory through an address, a one-cycle read strobe, a data input and a one-cycle completion pulse. The sequencer stalls in its wait steps until the completion pulse arrives, so the memory may take any number of cycles. Because there is only one bus, a two-operand add has to pass its first operand through the operand latch and its result through the result latch. Each operation therefore costs several steps.

Top module: `onebus_cpu`

## Requirements
- R1: While `rst_n` is low, `mem_rd`, `instr_done` and `zero_flag` are 0 and `mem_addr` is 0. After release, the first read fetches address 0, and this holds even when reset arrives in the middle of a memory wait.
- R2: Each operation begins with a fetch read whose address is the program counter. The fetch advances the program counter by 1 and takes L+3 cycles, where L is the number of cycles from the read strobe to the completion pulse.
- R3: `mem_rd` is high for exactly one cycle per access. `mem_addr` holds steady, and the sequencer does not advance, until `mem_done` is seen.
- R4: An instruction word has the opcode in bits [15:14], register A in [13:12], register B in [11:10] and the offset in [7:0]. Bits [9:8] have no effect.
- R5: Opcode 00 sets A to A+B modulo 2^16. The operation takes L+7 cycles in total.
- R6: Opcode 01 issues a second read at address B[7:0] and sets A to A plus the returned word modulo 2^16. The operation takes 2L+8 cycles.
- R7: Opcode 10 with the zero flag at 1 loads the program counter with (jump address + 1 + sign-extended offset). The operation takes L+7 cycles.
- R8: Opcode 10 with the zero flag at 0 continues at the jump address + 1. The operation takes L+4 cycles.
- R9: Opcode 11 changes no register and not the zero flag. It continues at the next address and takes L+4 cycles.
- R10: The zero flag is set to (written value == 0) whenever an add writes a register, and it holds its value on every other cycle.
- R11: At most one source drives the internal bus in any cycle.
- R12: `instr_done` is high for exactly the last cycle of each operation, and the next fetch read follows two cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 8 | Memory address, taken from the address latch |
| mem_rd | output | 1 | One-cycle read strobe |
| mem_rdata | input | 16 | Read data, valid while `mem_done` is high |
| mem_done | input | 1 | One-cycle completion pulse from memory |
| zero_flag | output | 1 | Zero result of the last register-writing add |
| instr_done | output | 1 | High in the final step of each operation |

## Verification
Registers come out of reset at zero, so the only address an indirect add can read at first is 0. That makes it hard to produce non-zero operands, a wrapping sum that sets the zero flag, and then a backward jump taken on that flag. The stimulus program puts a harmless opcode-11 word with a non-zero low byte at address 0, reads that word through register 0, and chains further indirect reads from it. An add then wraps to zero and sends control back into a jump loop. Reset is also dropped while a fetch is waiting on memory, and the run is repeated at zero and at long memory latency so that the stall lengths are exercised.

// File: rtl/onebus_pkg.sv
package onebus_pkg;

   localparam int OPC_W = 2;

   typedef enum logic [OPC_W-1:0] {
      OPC_ADD  = 2'b00,
      OPC_ADDM = 2'b01,
      OPC_JZ   = 2'b10,
      OPC_NOP  = 2'b11
   } opc_e;

   typedef enum logic [2:0] {
      ST_1 = 3'd0,
      ST_2 = 3'd1,
      ST_3 = 3'd2,
      ST_4 = 3'd3,
      ST_5 = 3'd4,
      ST_6 = 3'd5,
      ST_7 = 3'd6,
      ST_8 = 3'd7
   } step_e;

   // bus source slots
   localparam int SRC_PC  = 0;
   localparam int SRC_Z   = 1;
   localparam int SRC_MDR = 2;
   localparam int SRC_OFF = 3;
   localparam int SRC_GPR = 4;
   localparam int N_SRC   = 5;

   typedef struct packed {
      logic [N_SRC-1:0] drv;     // one-hot bus source
      logic             rd_b;    // register read select: 0 = field A, 1 = field B
      logic             ld_mar;
      logic             ld_pc;
      logic             ld_ir;
      logic             ld_y;
      logic             ld_z;
      logic             ld_gpr;
      logic             clr_y;
      logic             cin;
      logic             mem_rd;
      logic             stall;
      logic             fin;
   } ctl_t;

endpackage

// File: rtl/onebus_seq.sv
module onebus_seq
   import onebus_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  opc_e opc,
   input  logic zero,
   input  logic mem_done,
   output ctl_t ctl
);

   step_e step_q;
   step_e step_n;
   ctl_t  c;

   always_comb begin
      c = '0;
      case (step_q)
         ST_1: begin
            c.drv[SRC_PC] = 1'b1;
            c.ld_mar      = 1'b1;
            c.mem_rd      = 1'b1;
            c.clr_y       = 1'b1;
            c.cin         = 1'b1;
            c.ld_z        = 1'b1;
         end
         ST_2: begin
            c.drv[SRC_Z] = 1'b1;
            c.ld_pc      = 1'b1;
            c.stall      = 1'b1;
         end
         ST_3: begin
            c.drv[SRC_MDR] = 1'b1;
            c.ld_ir        = 1'b1;
         end
         ST_4: begin
            case (opc)
               OPC_ADD: begin
                  c.drv[SRC_GPR] = 1'b1;
                  c.ld_y         = 1'b1;
               end
               OPC_ADDM: begin
                  c.drv[SRC_GPR] = 1'b1;
                  c.rd_b         = 1'b1;
                  c.ld_mar       = 1'b1;
                  c.mem_rd       = 1'b1;
               end
               OPC_JZ: begin
                  if (zero) begin
                     c.drv[SRC_PC] = 1'b1;
                     c.ld_y        = 1'b1;
                  end else begin
                     c.fin = 1'b1;
                  end
               end
               default: c.fin = 1'b1;
            endcase
         end
         ST_5: begin
            case (opc)
               OPC_ADD: begin
                  c.drv[SRC_GPR] = 1'b1;
                  c.rd_b         = 1'b1;
                  c.ld_z         = 1'b1;
               end
               OPC_ADDM: begin
                  c.drv[SRC_GPR] = 1'b1;
                  c.ld_y         = 1'b1;
                  c.stall        = 1'b1;
               end
               OPC_JZ: begin
                  c.drv[SRC_OFF] = 1'b1;
                  c.ld_z         = 1'b1;
               end
               default: c.fin = 1'b1;
            endcase
         end
         ST_6: begin
            case (opc)
               OPC_ADD: begin
                  c.drv[SRC_Z] = 1'b1;
                  c.ld_gpr     = 1'b1;
               end
               OPC_ADDM: begin
                  c.drv[SRC_MDR] = 1'b1;
                  c.ld_z         = 1'b1;
               end
               OPC_JZ: begin
                  c.drv[SRC_Z] = 1'b1;
                  c.ld_pc      = 1'b1;
               end
               default: c.fin = 1'b1;
            endcase
         end
         ST_7: begin
            if (opc == OPC_ADDM) begin
               c.drv[SRC_Z] = 1'b1;
               c.ld_gpr     = 1'b1;
            end else begin
               c.fin = 1'b1;
            end
         end
         default: c.fin = 1'b1;
      endcase
   end

   always_comb begin
      if (c.fin)
         step_n = ST_1;
      else if (c.stall && !mem_done)
         step_n = step_q;
      else
         step_n = step_e'(step_q + 3'd1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         step_q <= ST_1;
      else
         step_q <= step_n;
   end

   assign ctl = c;

endmodule

// File: rtl/onebus_gpr.sv
module onebus_gpr #(
   parameter int DATA_W = 16,
   parameter int NREG   = 4,
   parameter int SEL_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [SEL_W-1:0]  wsel,
   input  logic [DATA_W-1:0] wdata,
   input  logic [SEL_W-1:0]  rsel,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] regs [NREG];

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '0;
         else if (we && (wsel == SEL_W'(g)))
            q <= wdata;
      end
      assign regs[g] = q;
   end

   assign rdata = regs[rsel];

endmodule

// File: rtl/onebus_alu.sv
module onebus_alu #(
   parameter int DATA_W = 16
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              clr_a,
   input  logic              cin,
   output logic [DATA_W-1:0] sum
);

   logic [DATA_W-1:0] a_gated;

   assign a_gated = clr_a ? '0 : a;
   assign sum     = a_gated + b + {{(DATA_W-1){1'b0}}, cin};

endmodule

// File: rtl/onebus_cpu.sv
module onebus_cpu
   import onebus_pkg::*;
#(
   parameter int              DATA_W     = 16,
   parameter int              ADDR_W     = 8,
   parameter int              NREG       = 4,
   parameter int              OFF_W      = 8,
   parameter bit              OFF_SIGNED = 1'b1,
   parameter logic [DATA_W-1:0] RESET_PC = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_done,
   output logic              zero_flag,
   output logic              instr_done
);

   localparam int SEL_W   = (NREG > 1) ? $clog2(NREG) : 1;
   localparam int OPC_LSB = DATA_W - OPC_W;
   localparam int RA_LSB  = OPC_LSB - SEL_W;
   localparam int RB_LSB  = RA_LSB - SEL_W;

   // elaboration-time parameter checks
   if (OPC_W + 2*SEL_W + OFF_W > DATA_W) begin : g_bad_fields
      $error("instruction fields do not fit in DATA_W");
   end
   if (ADDR_W > DATA_W) begin : g_bad_addr
      $error("ADDR_W must not exceed DATA_W");
   end
   if (NREG < 2 || (1 << SEL_W) != NREG) begin : g_bad_nreg
      $error("NREG must be a power of two, at least 2");
   end

   ctl_t              ctl;
   logic [DATA_W-1:0] pc_q, mar_q, mdr_q, ir_q, y_q, z_q;
   logic              zero_q;
   logic              rd_q;
   logic [DATA_W-1:0] bus;
   logic [DATA_W-1:0] alu_sum;
   logic [DATA_W-1:0] gpr_rdata;
   logic [DATA_W-1:0] off_ext;
   logic [SEL_W-1:0]  fld_a, fld_b, gpr_rsel;
   opc_e              opc;
   logic [N_SRC-1:0]  bus_drv;
   logic              seq_stall;
   logic              gpr_we;
   logic              unused_bits;

   assign opc      = opc_e'(ir_q[OPC_LSB +: OPC_W]);
   assign fld_a    = ir_q[RA_LSB +: SEL_W];
   assign fld_b    = ir_q[RB_LSB +: SEL_W];
   assign gpr_rsel = ctl.rd_b ? fld_b : fld_a;

   // offset extension variant
   if (OFF_W == DATA_W) begin : g_off_full
      assign off_ext = ir_q;
   end else if (OFF_SIGNED) begin : g_off_sext
      assign off_ext = {{(DATA_W-OFF_W){ir_q[OFF_W-1]}}, ir_q[OFF_W-1:0]};
   end else begin : g_off_zext
      assign off_ext = {{(DATA_W-OFF_W){1'b0}}, ir_q[OFF_W-1:0]};
   end

   onebus_seq u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .opc      (opc),
      .zero     (zero_q),
      .mem_done (mem_done),
      .ctl      (ctl)
   );

   onebus_gpr #(
      .DATA_W (DATA_W),
      .NREG   (NREG),
      .SEL_W  (SEL_W)
   ) u_gpr (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (ctl.ld_gpr),
      .wsel  (fld_a),
      .wdata (bus),
      .rsel  (gpr_rsel),
      .rdata (gpr_rdata)
   );

   onebus_alu #(
      .DATA_W (DATA_W)
   ) u_alu (
      .a     (y_q),
      .b     (bus),
      .clr_a (ctl.clr_y),
      .cin   (ctl.cin),
      .sum   (alu_sum)
   );

   // shared bus: AND-OR of gated sources
   logic [DATA_W-1:0] src  [N_SRC];
   logic [DATA_W-1:0] term [N_SRC];

   assign src[SRC_PC]  = pc_q;
   assign src[SRC_Z]   = z_q;
   assign src[SRC_MDR] = mdr_q;
   assign src[SRC_OFF] = off_ext;
   assign src[SRC_GPR] = gpr_rdata;

   for (genvar g = 0; g < N_SRC; g++) begin : g_bus_term
      assign term[g] = ctl.drv[g] ? src[g] : '0;
   end

   always_comb begin
      bus = '0;
      for (int i = 0; i < N_SRC; i++)
         bus = bus | term[i];
   end

   // special registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q   <= RESET_PC;
         mar_q  <= '0;
         mdr_q  <= '0;
         ir_q   <= '0;
         y_q    <= '0;
         z_q    <= '0;
         zero_q <= 1'b0;
         rd_q   <= 1'b0;
      end else begin
         if (ctl.ld_pc)  pc_q  <= bus;
         if (ctl.ld_mar) mar_q <= bus;
         if (mem_done)   mdr_q <= mem_rdata;
         if (ctl.ld_ir)  ir_q  <= bus;
         if (ctl.clr_y)
            y_q <= '0;
         else if (ctl.ld_y)
            y_q <= bus;
         if (ctl.ld_z)   z_q   <= alu_sum;
         if (ctl.ld_gpr) zero_q <= (bus == '0);
         rd_q <= ctl.mem_rd;
      end
   end

   assign mem_addr   = mar_q[ADDR_W-1:0];
   assign mem_rd     = rd_q;
   assign zero_flag  = zero_q;
   assign instr_done = ctl.fin;

   assign bus_drv   = ctl.drv;
   assign seq_stall = ctl.stall;
   assign gpr_we    = ctl.ld_gpr;

   assign unused_bits = ^{mar_q, ir_q};

endmodule

// File: rtl/onebus_cpu_chk.sv
module onebus_cpu_chk #(
   parameter int NSRC   = 5,
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NSRC-1:0]   bus_drv,
   input logic              stall,
   input logic              gpr_we,
   input logic              mem_rd,
   input logic              mem_done,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              zero_flag,
   input logic              instr_done
);

   // R11
   one_driver_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bus_drv));

   // R3
   rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |=> !mem_rd);

   // R3
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stall && !mem_done) |=> $stable(mem_addr));

   // R10
   zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !gpr_we |=> $stable(zero_flag));

   // R12
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      instr_done |=> !instr_done);

   // R12
   done_then_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      instr_done |-> ##2 mem_rd);

endmodule

bind onebus_cpu onebus_cpu_chk #(
   .NSRC   (onebus_pkg::N_SRC),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_drv    (bus_drv),
   .stall      (seq_stall),
   .gpr_we     (gpr_we),
   .mem_rd     (mem_rd),
   .mem_done   (mem_done),
   .mem_addr   (mem_addr),
   .zero_flag  (zero_flag),
   .instr_done (instr_done)
);

// File: tb/onebus_cpu_tb_top.sv
module onebus_cpu_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int MEM_LAT    = 2;
   localparam int PROG_N     = 16;

   // program words at addresses 0..15
   localparam logic [15:0] PROG [PROG_N] = '{
      16'hC0F0,  // 0  opcode 11, non-zero low byte (seed value)
      16'h5000,  // 1  R1 += mem[R0]
      16'h6400,  // 2  R2 += mem[R1]
      16'h8005,  // 3  jump +5 if zero
      16'h3B00,  // 4  R3 += R2, bits 9:8 set
      16'h3C00,  // 5  R3 += R3
      16'h4800,  // 6  R0 += mem[R2]
      16'h0C00,  // 7  R0 += R3 (wraps to zero)
      16'h8003,  // 8  jump +3 if zero
      16'hC000,  // 9  opcode 11
      16'hC3FF,  // 10 opcode 11 with junk fields
      16'hC000,  // 11 opcode 11
      16'h7C00,  // 12 R3 += mem[R3]
      16'h1400,  // 13 R1 += R1
      16'h0000,  // 14 R0 += R0
      16'h80F3   // 15 jump -13 if zero
   };

   logic        clk;
   logic        rst_n;
   logic [7:0]  mem_addr;
   logic        mem_rd;
   logic [15:0] mem_rdata;
   logic        mem_done;
   logic        zero_flag;
   logic        instr_done;

   logic [15:0] mem [256];
   int          lat;
   int          cyc;
   int          n_chk;
   int          n_err;
   bit          finished;

   onebus_cpu dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .mem_addr   (mem_addr),
      .mem_rd     (mem_rd),
      .mem_rdata  (mem_rdata),
      .mem_done   (mem_done),
      .zero_flag  (zero_flag),
      .instr_done (instr_done)
   );

   initial begin
      clk = 1'b0;
      forever #(CLK_PERIOD/2) clk = ~clk;
   end

   always @(posedge clk) cyc <= cyc + 1;

   // memory responder: done arrives lat cycles after the read strobe
   initial begin
      bit         busy;
      int         cnt;
      logic [7:0] a_l;
      busy      = 1'b0;
      cnt       = 0;
      a_l       = '0;
      mem_done  = 1'b0;
      mem_rdata = '0;
      forever begin
         @(negedge clk);
         mem_done = 1'b0;
         if (!rst_n) begin
            busy = 1'b0;
         end else if (busy) begin
            if (cnt == 0) begin
               mem_done  = 1'b1;
               mem_rdata = mem[a_l];
               busy      = 1'b0;
            end else begin
               cnt = cnt - 1;
            end
         end else if (mem_rd) begin
            a_l = mem_addr;
            if (lat == 0) begin
               mem_done  = 1'b1;
               mem_rdata = mem[a_l];
            end else begin
               busy = 1'b1;
               cnt  = lat - 1;
            end
         end
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic wait_rd(output logic [7:0] a);
      do @(negedge clk); while (!mem_rd);
      a = mem_addr;
   endtask

   task automatic wait_done();
      do @(negedge clk); while (!instr_done);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      @(negedge clk);
      // R1: reset state at the ports
      chk(mem_rd == 1'b0,     "R1", "mem_rd in reset",     32'(mem_rd), 0);
      chk(instr_done == 1'b0, "R1", "instr_done in reset", 32'(instr_done), 0);
      chk(zero_flag == 1'b0,  "R1", "zero_flag in reset",  32'(zero_flag), 0);
      chk(mem_addr == 8'h00,  "R1", "mem_addr in reset",   32'(mem_addr), 0);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   // executes n operations against an ISA-level model
   task automatic run_prog(input int n, input int l);
      logic [15:0] mr [4];
      logic [15:0] mpc;
      logic        mz;
      logic [7:0]  a;
      logic [15:0] w;
      logic [1:0]  op, ra, rb;
      logic [15:0] sx;
      int          prev;
      int          now;
      int          exp_len;
      string       tag;
      lat  = l;
      for (int i = 0; i < 4; i++) mr[i] = '0;
      mpc  = '0;
      mz   = 1'b0;
      prev = -1;
      for (int k = 0; k < n; k++) begin
         wait_rd(a);
         chk(a == mpc[7:0], (k == 0) ? "R1" : "R2", "fetch address", 32'(a), 32'(mpc[7:0]));
         w  = mem[mpc[7:0]];
         op = w[15:14];
         ra = w[13:12];
         rb = w[11:10];
         sx = {{8{w[7]}}, w[7:0]};
         if (op == 2'b01) begin
            wait_rd(a);
            // register B value seen as the data address (R5 R6 R11 results)
            chk(a == mr[rb][7:0], "R6", "data address R5 R11", 32'(a), 32'(mr[rb][7:0]));
         end
         wait_done();
         now = cyc;
         case (op)
            2'b00: begin
               mr[ra] = mr[ra] + mr[rb];
               mz = (mr[ra] == 16'h0);
               mpc = mpc + 16'd1;
               exp_len = l + 7;
               tag = "R5 R4";
            end
            2'b01: begin
               mr[ra] = mr[ra] + mem[mr[rb][7:0]];
               mz = (mr[ra] == 16'h0);
               mpc = mpc + 16'd1;
               exp_len = 2*l + 8;
               tag = "R6 R3";
            end
            2'b10: begin
               if (mz) begin
                  mpc = mpc + 16'd1 + sx;
                  exp_len = l + 7;
                  tag = "R7";
               end else begin
                  mpc = mpc + 16'd1;
                  exp_len = l + 4;
                  tag = "R8";
               end
            end
            default: begin
               mpc = mpc + 16'd1;
               exp_len = l + 4;
               tag = "R9";
            end
         endcase
         if (prev >= 0)
            chk((now - prev) == exp_len, tag, "operation length R2", 32'(now - prev), 32'(exp_len));
         chk(zero_flag == mz, "R10", "zero flag after operation", 32'(zero_flag), 32'(mz));
         @(negedge clk);
         chk(instr_done == 1'b0, "R12", "instr_done one cycle", 32'(instr_done), 0);
         prev = now;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         n_chk++;
         n_err++;
         $display("FAIL R3 watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      logic [7:0] a;
      finished = 1'b0;
      n_chk = 0;
      n_err = 0;
      cyc   = 0;
      lat   = MEM_LAT;
      rst_n = 1'b0;
      for (int i = 0; i < 256; i++) mem[i] = '0;
      for (int i = 0; i < PROG_N; i++) mem[i] = PROG[i];
      mem[8'hF0] = 16'h0010;
      mem[8'h10] = 16'hFFE0;
      mem[8'h20] = 16'h0001;
      mem[8'h21] = 16'h7FFF;
      @(negedge clk);

      do_reset();
      run_prog(40, MEM_LAT);

      // R1: reset dropped while a fetch waits on memory
      wait_rd(a);
      do_reset();
      run_prog(14, 0);

      do_reset();
      run_prog(14, 4);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule